// File: doc/BRIEF.md
# Edge-Latched External Interrupt Controller

This block gathers a set of external interrupt request lines, which may change at any time with no relation to the processor clock, and turns them into one synchronous external-interrupt output toward a processor core. Each line first passes through a flop synchroniser. Its rising edge is then captured into a pending bit. The bit stays set after the line falls again, so a short pulse is never lost.

Software reaches the block through a small 32-bit register port with a valid/ready request side and a one-cycle registered response. It can program a per-source enable mask. It claims the winning source by reading the claim/complete word and signals the end of service by writing the claimed ID back to the same word. Between a claim and its matching completion, the controller sits in a claimed state. In that state the output is low, further claims return nothing, and new rising edges are not captured. Priority is fixed: the lowest source index wins.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset the enable mask is zero, no source is pending, the controller is idle, `ext_irq` and `reg_rvalid` are low, and a read of the enable word returns 0.
- R2: Each request line passes through a two-flop synchroniser and one edge flop. A line first sampled high at clock edge k raises `ext_irq` after edge k+2, provided the source is enabled and the controller is idle.
- R3: A captured request stays pending after its line falls, until it is claimed. A line held high after a claim and completion raises no new request, because only rising edges are captured.
- R4: The enable word is word index 0 (byte offset 0x0, address bits [ADDR_W-1:2] equal to 0). Bit i gates source i, bits at and above NUM_IRQS are dropped on write, and a read returns the mask zero-extended. A disabled source still latches its edge and drives `ext_irq` once it is enabled.
- R5: A read of the claim/complete word (byte offset 0x4, word index 1) while the controller is idle returns the ID of the lowest-indexed source that is both pending and enabled, where ID = index + 1. It clears that source's pending bit and enters the claimed state.
- R6: A claim read while idle with no source that is both pending and enabled returns 0 and changes no state.
- R7: While claimed, `ext_irq` is low, claim reads return 0, and rising edges on the request lines are not captured.
- R8: A write to the claim/complete word whose full 32-bit data equals the claimed ID returns the controller to idle. Any other value leaves it claimed.
- R9: `ext_irq` is high exactly when the controller is idle and at least one enabled source is pending.
- R10: `reg_ready` is always high after reset. Every accepted request produces `reg_rvalid` in the next cycle. A write responds with data 0. Reads of word indices other than 0 and 1 return 0, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| irq_in | input | NUM_IRQS | Asynchronous interrupt request lines |
| reg_valid | input | 1 | Register request valid |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte address of the request |
| reg_wdata | input | DATA_W | Write data |
| reg_ready | output | 1 | Request accepted (always high) |
| reg_rvalid | output | 1 | Response valid, one cycle after acceptance |
| reg_rdata | output | DATA_W | Response data |
| ext_irq | output | 1 | Synchronous external interrupt to the core |

## Verification
The bench builds the block with six sources, so that enable bits 6 to 31 exist on the bus and can be shown to be dropped. The IDs then need three bits, which makes a completion value with high bits set distinguishable from a valid ID. The address is five bits wide, which leaves word indices 2 to 7 unmapped; their reads and writes can be shown to reach neither the mask nor the claim logic. With that many sources, random toggling regularly makes several edges arrive together and edges land during a claim, so both the lowest-index selection and the dropping of edges in the claimed state get exercised.

// File: rtl/edge_irq_pkg.sv
package edge_irq_pkg;

   // Byte-address bits below the word index
   localparam int unsigned REG_WORD_LSB = 2;

   // Word indices of the register map
   localparam int unsigned SLOT_ENABLE = 0;
   localparam int unsigned SLOT_CLAIM  = 1;

   typedef enum logic {
      ARB_IDLE    = 1'b0,
      ARB_CLAIMED = 1'b1
   } arb_state_e;

endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
   parameter int unsigned NUM_IRQS    = 8,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_IRQS-1:0] irq_async,
   output logic [NUM_IRQS-1:0] rise
);

   if (SYNC_STAGES < 2) begin : g_bad_stages
      $error("irq_sync_edge: SYNC_STAGES must be at least 2");
   end

   for (genvar g = 0; g < NUM_IRQS; g++) begin : g_src
      // [SYNC_STAGES-1:0] synchroniser, [SYNC_STAGES] previous value
      logic [SYNC_STAGES:0] chain_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= '0;
         end else begin
            chain_q <= {chain_q[SYNC_STAGES-1:0], irq_async[g]};
         end
      end

      assign rise[g] = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
   end

endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
   import edge_irq_pkg::*;
#(
   parameter int unsigned NUM_IRQS = 8,
   parameter int unsigned ID_W     = $clog2(NUM_IRQS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_IRQS-1:0] rise,
   input  logic [NUM_IRQS-1:0] enable,
   input  logic                claim_req,
   input  logic                done_req,
   input  logic [ID_W-1:0]     done_id,
   output logic [ID_W-1:0]     claim_id,
   output logic                claimed,
   output logic [NUM_IRQS-1:0] pending,
   output logic                irq_out
);

   arb_state_e          state_q, state_d;
   logic [ID_W-1:0]     cid_q, cid_d;
   logic [NUM_IRQS-1:0] pend_q, pend_d;
   logic [NUM_IRQS-1:0] cand, win_hot, clr, set;
   logic [ID_W-1:0]     win_id;
   logic                idle;

   assign idle = (state_q == ARB_IDLE);
   assign cand = pend_q & enable;

   // Fixed priority: lowest index wins
   always_comb begin
      win_id  = '0;
      win_hot = '0;
      for (int i = NUM_IRQS - 1; i >= 0; i--) begin
         if (cand[i]) begin
            win_id  = ID_W'(i + 1);
            win_hot = NUM_IRQS'(1) << i;
         end
      end
   end

   always_comb begin
      state_d = state_q;
      cid_d   = cid_q;
      clr     = '0;
      if (idle && claim_req && (win_id != '0)) begin
         state_d = ARB_CLAIMED;
         cid_d   = win_id;
         clr     = win_hot;
      end
      if (!idle && done_req && (done_id == cid_q)) begin
         state_d = ARB_IDLE;
      end
   end

   assign set    = idle ? rise : '0;
   assign pend_d = (pend_q & ~clr) | set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ARB_IDLE;
         cid_q   <= '0;
         pend_q  <= '0;
      end else begin
         state_q <= state_d;
         cid_q   <= cid_d;
         pend_q  <= pend_d;
      end
   end

   assign claim_id = idle ? win_id : '0;
   assign claimed  = !idle;
   assign pending  = pend_q;
   assign irq_out  = idle && (cand != '0);

endmodule

// File: rtl/irq_regport.sv
module irq_regport
   import edge_irq_pkg::*;
#(
   parameter int unsigned NUM_IRQS = 8,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned ID_W     = $clog2(NUM_IRQS + 1)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_write,
   input  logic [ADDR_W-1:0]   req_addr,
   input  logic [DATA_W-1:0]   req_wdata,
   output logic                req_ready,
   output logic                rsp_valid,
   output logic [DATA_W-1:0]   rsp_data,
   input  logic [ID_W-1:0]     claim_id,
   output logic [NUM_IRQS-1:0] enable,
   output logic                claim_req,
   output logic                done_req,
   output logic [ID_W-1:0]     done_id
);

   localparam int unsigned WORD_W = ADDR_W - REG_WORD_LSB;

   logic [WORD_W-1:0]   word;
   logic                hit_en, hit_cl;
   logic [NUM_IRQS-1:0] enable_q;
   logic                rsp_valid_q;
   logic [DATA_W-1:0]   rsp_data_q, rd_mux;

   assign req_ready = 1'b1;
   assign word      = req_addr[ADDR_W-1:REG_WORD_LSB];
   assign hit_en    = req_valid && (word == WORD_W'(SLOT_ENABLE));
   assign hit_cl    = req_valid && (word == WORD_W'(SLOT_CLAIM));

   assign claim_req = hit_cl && !req_write;
   assign done_req  = hit_cl && req_write && ((req_wdata >> ID_W) == '0);
   assign done_id   = req_wdata[ID_W-1:0];

   always_comb begin
      rd_mux = '0;
      if (hit_en) begin
         rd_mux = DATA_W'(enable_q);
      end else if (hit_cl) begin
         rd_mux = DATA_W'(claim_id);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q    <= '0;
         rsp_valid_q <= 1'b0;
         rsp_data_q  <= '0;
      end else begin
         if (hit_en && req_write) begin
            enable_q <= req_wdata[NUM_IRQS-1:0];
         end
         rsp_valid_q <= req_valid;
         rsp_data_q  <= (req_valid && !req_write) ? rd_mux : '0;
      end
   end

   assign enable    = enable_q;
   assign rsp_valid = rsp_valid_q;
   assign rsp_data  = rsp_data_q;

endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
   import edge_irq_pkg::*;
#(
   parameter int unsigned NUM_IRQS    = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 32
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_IRQS-1:0] irq_in,
   input  logic                reg_valid,
   input  logic                reg_write,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic                reg_ready,
   output logic                reg_rvalid,
   output logic [DATA_W-1:0]   reg_rdata,
   output logic                ext_irq
);

   localparam int unsigned ID_W = $clog2(NUM_IRQS + 1);

   if (NUM_IRQS < 1 || NUM_IRQS >= DATA_W) begin : g_bad_count
      $error("edge_irq_ctrl: NUM_IRQS must be in 1..DATA_W-1");
   end
   if (ADDR_W < REG_WORD_LSB + 1) begin : g_bad_addr
      $error("edge_irq_ctrl: ADDR_W too small for two words");
   end

   logic [NUM_IRQS-1:0] src_rise;
   logic [NUM_IRQS-1:0] reg_enable;
   logic [NUM_IRQS-1:0] arb_pending;
   logic                arb_claimed;
   logic                claim_req, done_req;
   logic [ID_W-1:0]     done_id, claim_id;

   irq_sync_edge #(
      .NUM_IRQS    (NUM_IRQS),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_front (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq_async (irq_in),
      .rise      (src_rise)
   );

   irq_regport #(
      .NUM_IRQS (NUM_IRQS),
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .ID_W     (ID_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (reg_valid),
      .req_write (reg_write),
      .req_addr  (reg_addr),
      .req_wdata (reg_wdata),
      .req_ready (reg_ready),
      .rsp_valid (reg_rvalid),
      .rsp_data  (reg_rdata),
      .claim_id  (claim_id),
      .enable    (reg_enable),
      .claim_req (claim_req),
      .done_req  (done_req),
      .done_id   (done_id)
   );

   irq_arbiter #(
      .NUM_IRQS (NUM_IRQS),
      .ID_W     (ID_W)
   ) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .rise      (src_rise),
      .enable    (reg_enable),
      .claim_req (claim_req),
      .done_req  (done_req),
      .done_id   (done_id),
      .claim_id  (claim_id),
      .claimed   (arb_claimed),
      .pending   (arb_pending),
      .irq_out   (ext_irq)
   );

endmodule

// File: rtl/edge_irq_chk.sv
module edge_irq_chk #(
   parameter int unsigned NUM_IRQS = 8,
   parameter int unsigned ADDR_W   = 4,
   parameter int unsigned DATA_W   = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                reg_valid,
   input logic                reg_write,
   input logic [ADDR_W-1:0]   reg_addr,
   input logic                reg_ready,
   input logic                reg_rvalid,
   input logic [DATA_W-1:0]   reg_rdata,
   input logic                ext_irq,
   input logic                claimed,
   input logic [NUM_IRQS-1:0] pending,
   input logic [NUM_IRQS-1:0] enable
);

   logic claim_rd, claim_wr;
   assign claim_rd = reg_valid && !reg_write && ((reg_addr >> 2) == ADDR_W'(1));
   assign claim_wr = reg_valid &&  reg_write && ((reg_addr >> 2) == ADDR_W'(1));

   // R1
   reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!claimed && pending == '0 && enable == '0 && !ext_irq && !reg_rvalid));

   // R3
   pending_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !claim_rd |=> ((pending & $past(pending)) == $past(pending)));

   // R5
   claim_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_rd && !claimed && ((pending & enable) != '0)) |=> (claimed && reg_rdata != '0));

   // R6
   empty_claim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (claim_rd && !claimed && ((pending & enable) == '0)) |=> (!claimed && reg_rdata == '0));

   // R7
   claimed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      claimed |-> !ext_irq);

   // R7
   claimed_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      claimed |=> $stable(pending));

   // R8
   stay_claimed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (claimed && !claim_wr) |=> claimed);

   // R10
   rsp_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_valid |=> reg_rvalid);

   // R10
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_valid |=> !reg_rvalid);

   // R10
   ready_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_ready);

endmodule

bind edge_irq_ctrl edge_irq_chk #(
   .NUM_IRQS (NUM_IRQS),
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_valid  (reg_valid),
   .reg_write  (reg_write),
   .reg_addr   (reg_addr),
   .reg_ready  (reg_ready),
   .reg_rvalid (reg_rvalid),
   .reg_rdata  (reg_rdata),
   .ext_irq    (ext_irq),
   .claimed    (arb_claimed),
   .pending    (arb_pending),
   .enable     (reg_enable)
);

// File: tb/edge_irq_ctrl_test.sv
`timescale 1ns/1ps
module edge_irq_ctrl_test;

   localparam int unsigned NI = 6;
   localparam int unsigned AW = 5;
   localparam int unsigned DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NI-1:0] irq_in = '0;
   logic          reg_valid = 1'b0;
   logic          reg_write = 1'b0;
   logic [AW-1:0] reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic          reg_ready, reg_rvalid, ext_irq;
   logic [DW-1:0] reg_rdata;

   int n_chk = 0;
   int n_fail = 0;
   bit chk_on = 1'b0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   edge_irq_ctrl #(
      .NUM_IRQS    (NI),
      .SYNC_STAGES (2),
      .ADDR_W      (AW),
      .DATA_W      (DW)
   ) uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .irq_in     (irq_in),
      .reg_valid  (reg_valid),
      .reg_write  (reg_write),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_ready  (reg_ready),
      .reg_rvalid (reg_rvalid),
      .reg_rdata  (reg_rdata),
      .ext_irq    (ext_irq)
   );

   // Bench model built from the requirements
   logic [NI-1:0] m_en, m_pend, m_s1, m_s2, m_s3;
   bit            m_claimed;
   int            m_cid;
   bit            m_rvalid;
   logic [DW-1:0] m_rdata;

   function automatic int pick(input logic [NI-1:0] m);
      for (int i = 0; i < NI; i++) if (m[i]) return i + 1;
      return 0;
   endfunction

   always @(posedge clk) begin : model
      logic [NI-1:0] rise_v, clr_v;
      bit            was_claimed;
      int            w, id;
      if (!rst_n) begin
         m_en = '0; m_pend = '0; m_s1 = '0; m_s2 = '0; m_s3 = '0;
         m_claimed = 1'b0; m_cid = 0; m_rvalid = 1'b0; m_rdata = '0;
      end else begin
         rise_v      = m_s2 & ~m_s3;
         clr_v       = '0;
         was_claimed = m_claimed;
         m_rvalid    = reg_valid;
         m_rdata     = '0;
         if (reg_valid) begin
            w = int'(reg_addr >> 2);
            if (!reg_write) begin
               if (w == 0) m_rdata = DW'(m_en);
               else if (w == 1 && !m_claimed) begin
                  id = pick(m_pend & m_en);
                  if (id != 0) begin
                     clr_v[id-1] = 1'b1;
                     m_claimed   = 1'b1;
                     m_cid       = id;
                  end
                  m_rdata = DW'(id);
               end
            end else begin
               if (w == 0) m_en = reg_wdata[NI-1:0];
               else if (w == 1 && m_claimed && reg_wdata == DW'(m_cid)) m_claimed = 1'b0;
            end
         end
         m_pend = (m_pend & ~clr_v) | (was_claimed ? '0 : rise_v);
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = irq_in;
      end
   end

   task automatic check(input bit ok, input string req, input string what,
                        input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // Continuous comparison against the model
   always @(negedge clk) begin
      if (chk_on && !done) begin
         check(ext_irq === (!m_claimed && ((m_pend & m_en) != '0)), "R9", "ext_irq vs model",
               DW'(ext_irq), DW'(!m_claimed && ((m_pend & m_en) != '0)));
         check(reg_rvalid === m_rvalid, "R10", "rvalid vs model", DW'(reg_rvalid), DW'(m_rvalid));
         if (m_rvalid)
            check(reg_rdata === m_rdata, "R10", "rdata vs model", reg_rdata, m_rdata);
      end
   end

   task automatic bus(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      output logic [DW-1:0] rd);
      @(negedge clk);
      reg_valid = 1'b1; reg_write = wr; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_valid = 1'b0;
      rd = reg_rdata;
   endtask

   task automatic pulse(input logic [NI-1:0] m);
      @(negedge clk); irq_in = irq_in | m;
      @(negedge clk); irq_in = irq_in & ~m;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run;
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog (all requirements): actual 0 expected 1 (run completed)");
      finish_run();
   end

   initial begin
      logic [DW-1:0] rd;
      int            kind;
      void'($urandom(32'd7741));
      idle(4);
      rst_n = 1'b1;
      chk_on = 1'b1;
      @(negedge clk);

      // R1 reset state
      check(ext_irq == 1'b0, "R1", "ext_irq after reset", DW'(ext_irq), 0);
      check(reg_rvalid == 1'b0, "R1", "rvalid after reset", DW'(reg_rvalid), 0);
      check(reg_ready == 1'b1, "R10", "ready high", DW'(reg_ready), 1);
      bus(1'b0, 5'h00, '0, rd);
      check(rd == 0, "R1", "enable after reset", rd, 0);

      // R4 enable mask, upper bits dropped
      bus(1'b1, 5'h00, 32'hFFFF_FFFF, rd);
      check(rd == 0, "R10", "write response data", rd, 0);
      bus(1'b0, 5'h00, '0, rd);
      check(rd == 32'h3F, "R4", "enable readback", rd, 32'h3F);

      // R2 sync latency, R3 pulse held
      pulse(6'b001000);
      check(ext_irq == 1'b0, "R2", "ext_irq after edge k", DW'(ext_irq), 0);
      @(negedge clk);
      check(ext_irq == 1'b0, "R2", "ext_irq after edge k+1", DW'(ext_irq), 0);
      @(negedge clk);
      check(ext_irq == 1'b1, "R2", "ext_irq after edge k+2", DW'(ext_irq), 1);
      idle(5);
      check(ext_irq == 1'b1, "R3", "pulse still pending", DW'(ext_irq), 1);

      // R5 claim, R7 output low while claimed
      bus(1'b0, 5'h04, '0, rd);
      check(rd == 4, "R5", "claim id of source 3", rd, 4);
      check(ext_irq == 1'b0, "R7", "ext_irq while claimed", DW'(ext_irq), 0);

      // R7 edges ignored while claimed, R8 completion match
      pulse(6'b000010);
      idle(3);
      bus(1'b0, 5'h04, '0, rd);
      check(rd == 0, "R7", "claim while claimed", rd, 0);
      bus(1'b1, 5'h04, 32'd2, rd);
      idle(1);
      check(ext_irq == 1'b0, "R8", "wrong id keeps claimed", DW'(ext_irq), 0);
      bus(1'b1, 5'h04, 32'h0000_0104, rd);
      bus(1'b0, 5'h04, '0, rd);
      check(rd == 0, "R8", "id with high bits not a completion", rd, 0);
      bus(1'b1, 5'h04, 32'd4, rd);
      idle(2);
      check(ext_irq == 1'b0, "R7", "edge during claim dropped", DW'(ext_irq), 0);
      bus(1'b0, 5'h04, '0, rd);
      check(rd == 0, "R6", "empty claim returns 0", rd, 0);

      // R4 disabled source latches, R9 output
      bus(1'b1, 5'h00, 32'h20, rd);
      pulse(6'b100100);
      idle(2);
      check(ext_irq == 1'b1, "R9", "enabled source pending", DW'(ext_irq), 1);
      bus(1'b0, 5'h04, '0, rd);
      check(rd == 6, "R5", "claim masked winner", rd, 6);
      bus(1'b1, 5'h04, 32'd6, rd);
      idle(1);
      check(ext_irq == 1'b0, "R4", "disabled pending hidden", DW'(ext_irq), 0);
      bus(1'b1, 5'h00, 32'h3F, rd);
      check(ext_irq == 1'b1, "R4", "pending shown once enabled", DW'(ext_irq), 1);
      bus(1'b0, 5'h04, '0, rd);
      check(rd == 3, "R5", "claim source 2", rd, 3);
      bus(1'b1, 5'h04, 32'd3, rd);

      // R5 lowest index wins
      pulse(6'b010001);
      idle(2);
      bus(1'b0, 5'h04, '0, rd);
      check(rd == 1, "R5", "lowest index first", rd, 1);
      bus(1'b1, 5'h04, 32'd1, rd);
      bus(1'b0, 5'h04, '0, rd);
      check(rd == 5, "R5", "next source after completion", rd, 5);
      bus(1'b1, 5'h04, 32'd5, rd);
      check(ext_irq == 1'b0, "R9", "nothing pending", DW'(ext_irq), 0);

      // R10 unmapped words
      bus(1'b0, 5'h08, '0, rd);
      check(rd == 0, "R10", "unmapped word 2 read", rd, 0);
      bus(1'b0, 5'h14, '0, rd);
      check(rd == 0, "R10", "unmapped word 5 read", rd, 0);
      bus(1'b1, 5'h0C, 32'h0, rd);
      bus(1'b1, 5'h10, 32'h0, rd);
      bus(1'b0, 5'h00, '0, rd);
      check(rd == 32'h3F, "R10", "unmapped write ignored", rd, 32'h3F);

      // R3 held level does not retrigger
      @(negedge clk); irq_in[0] = 1'b1;
      idle(4);
      bus(1'b0, 5'h04, '0, rd);
      check(rd == 1, "R3", "level source claimed", rd, 1);
      bus(1'b1, 5'h04, 32'd1, rd);
      idle(4);
      check(ext_irq == 1'b0, "R3", "held level no retrigger", DW'(ext_irq), 0);
      @(negedge clk); irq_in[0] = 1'b0;
      idle(3);

      // Random phase, checked by the model every cycle
      for (int c = 0; c < 4000; c++) begin
         @(negedge clk);
         for (int b = 0; b < NI; b++) if ($urandom_range(5) == 0) irq_in[b] = ~irq_in[b];
         if ($urandom_range(2) == 0) begin
            reg_valid = 1'b1;
            kind = $urandom_range(5);
            case (kind)
               0: begin reg_write = 1'b0; reg_addr = 5'h00; end
               1: begin reg_write = 1'b1; reg_addr = 5'h00; reg_wdata = $urandom; end
               2: begin reg_write = 1'b0; reg_addr = 5'h04; end
               3: begin reg_write = 1'b1; reg_addr = 5'h04;
                        reg_wdata = m_claimed ? DW'(m_cid) : DW'($urandom_range(6)); end
               4: begin reg_write = 1'b1; reg_addr = 5'h04; reg_wdata = DW'($urandom_range(7)); end
               default: begin reg_write = 1'($urandom_range(1));
                        reg_addr = AW'($urandom_range(7, 2) << 2); reg_wdata = $urandom; end
            endcase
         end else begin
            reg_valid = 1'b0;
         end
      end
      @(negedge clk);
      reg_valid = 1'b0;
      idle(2);
      finish_run();
   end

endmodule